// File: doc/BRIEF.md
# Three-Channel Triggered Word Mover

This block is a direct memory access engine with three independent channels behind one 32-bit processor register port. Each channel is programmed with a source address, a destination address, a byte count, separate step settings for the two addresses, a trigger selector, an enable bit and a software start bit. Once the selected trigger condition is seen, the channel copies data one 32-bit word at a time. Each word is a read on a shared request/acknowledge memory port followed by a write of the same data. After every word both addresses advance by their programmed steps and the remaining count drops by four bytes.

When the count is used up, the channel clears its busy flag and pulses its done output for one cycle. The channels share the memory port. Whenever the port is free between words, the lowest-numbered busy channel gets the next word, so a higher-priority channel can cut in between the words of a lower-priority run but never inside a word. Channel 0 carries a 20-bit byte counter and the other two carry 12-bit counters.

Top module: `dma3_engine`

## Requirements
- R1: Channel c has its registers at byte address 0x20*c + offset, using reg_addr_i[6:5] as the channel and reg_addr_i[4:2] as the offset. Offset 0x00 is the source address and 0x04 the destination address, both in bits 26:0. Offset 0x08 is the byte count, in bits 19:0 for channel 0 and bits 11:0 for channels 1 and 2. Offset 0x0C holds the source step in bit 8 and the destination step code in bits 2:0. Offset 0x14 holds the trigger code in bits 2:0. Unimplemented bits read 0.
- R2: Trigger codes 0 to 6 select trig_i bits 0 to 6 respectively, and code 7 selects the software start bit. No source starts a run unless the enable bit (offset 0x10 bit 8) is 1.
- R3: A hardware trigger acts on its rising edge only, so an input held high starts a single run. Edges that arrive while the channel is busy are dropped.
- R4: Each word reads the current source address and then writes the data that was read to the current destination address (mem_we_o 0 for the read, 1 for the write).
- R5: A source step of 0 keeps the source address fixed. A source step of 1 adds 4 after each word.
- R6: Destination step code 0 keeps the destination address fixed. Code k from 1 to 7 adds 2^k bytes after each word.
- R7: A run moves ceil(count/4) words. A count of 0 stands for 2^W bytes, where W is the channel's counter width. The count register itself is not changed by a run.
- R8: done_o[c] is high for exactly one cycle after the final write of a run is acknowledged, and busy (offset 0x10 bit 4, read-only) is 0 from then on.
- R9: Between words, the lowest-numbered busy channel wins the memory port. A word that has started always completes before another channel is served.
- R10: The start bit (offset 0x10 bit 0) clears itself when its run begins and reads 0 from then on. Writes to it while the channel is busy are ignored.
- R11: While mem_req_o is high and mem_ack_i is low, the request, address and direction hold unchanged in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_wr_i | input | 1 | Register write strobe |
| reg_addr_i | input | 7 | Register byte address |
| reg_wdata_i | input | 32 | Register write data |
| reg_rdata_o | output | 32 | Register read data for reg_addr_i (combinational) |
| trig_i | input | 7 | Hardware trigger sources, selected by codes 0 to 6 |
| mem_req_o | output | 1 | Memory request |
| mem_we_o | output | 1 | 1 for a write, 0 for a read |
| mem_addr_o | output | 27 | Memory byte address |
| mem_wdata_o | output | 32 | Memory write data |
| mem_rdata_i | input | 32 | Memory read data, sampled with mem_ack_i |
| mem_ack_i | input | 1 | Memory acknowledge, completes the current request |
| done_o | output | 3 | Per-channel end-of-run pulse |

## Verification
The copy function runs in several forms, and each form exposes a different class of fault. A short software-started run shows the read/write pairing and the source increment. Runs that use destination codes 0, 1, 3 and 7 tell the power-of-two decode apart from a linear one, and a fixed source address separates the two step paths. Each trigger code is paired with a pulse on a neighbouring input, which confirms that the mapping from codes to sources is exact. A trigger held high, and another pulsed during a run, shows edge detection working against level sensing. Three channels started while a long acknowledge latency is in force yield a read order that only correct priority, applied between words, can produce. A zero count on a 12-bit channel and a count that is not a multiple of four cover the end-of-count rule.

// File: rtl/dma3_pkg.sv
package dma3_pkg;
  localparam int NUM_SRC  = 7;  // hardware trigger inputs
  localparam int SEL_W    = 3;
  localparam int STEP_W   = 3;
  localparam logic [SEL_W-1:0] SEL_SOFT = 3'd7;

  localparam logic [2:0] OFF_SRC  = 3'd0;
  localparam logic [2:0] OFF_DST  = 3'd1;
  localparam logic [2:0] OFF_CNT  = 3'd2;
  localparam logic [2:0] OFF_STEP = 3'd3;
  localparam logic [2:0] OFF_CTRL = 3'd4;
  localparam logic [2:0] OFF_TSEL = 3'd5;

  typedef enum logic [1:0] {
    MV_IDLE = 2'd0,
    MV_RD   = 2'd1,
    MV_WR   = 2'd2
  } mv_state_e;
endpackage

// File: rtl/dma3_channel.sv
module dma3_channel
  import dma3_pkg::*;
#(
  parameter int CNT_W  = 12,
  parameter int ADDR_W = 27
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wr_i,
  input  logic [2:0]        off_i,
  input  logic [31:0]       wdata_i,
  output logic [31:0]       rdata_o,
  input  logic [NUM_SRC-1:0] trig_i,
  input  logic              step_i,
  output logic              busy_o,
  output logic              done_o,
  output logic [ADDR_W-1:0] src_o,
  output logic [ADDR_W-1:0] dst_o
);
  localparam int REM_W = CNT_W + 1;

  logic [ADDR_W-1:0] src_q, dst_q;
  logic [CNT_W-1:0]  cnt_q;
  logic              sstep_q;
  logic [STEP_W-1:0] dstep_q;
  logic              en_q, start_q, busy_q, done_q;
  logic [SEL_W-1:0]  tsel_q;
  logic [REM_W-1:0]  rem_q;
  logic [NUM_SRC-1:0] trig_q;

  logic [NUM_SRC-1:0] rise;
  logic [NUM_SRC:0]   src_vec;
  logic               fire, last;
  logic [7:0]         dinc;

  assign rise    = trig_i & ~trig_q;
  assign src_vec = {start_q, rise};
  assign fire    = en_q & ~busy_q & src_vec[tsel_q];
  assign last    = (rem_q <= REM_W'(4));
  assign dinc    = (dstep_q == '0) ? 8'd0 : (8'd1 << dstep_q);

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      src_q   <= '0;
      dst_q   <= '0;
      cnt_q   <= '0;
      sstep_q <= 1'b0;
      dstep_q <= '0;
      en_q    <= 1'b0;
      start_q <= 1'b0;
      tsel_q  <= '0;
      busy_q  <= 1'b0;
      done_q  <= 1'b0;
      rem_q   <= '0;
      trig_q  <= '0;
    end else begin
      trig_q <= trig_i;
      done_q <= 1'b0;
      if (wr_i) begin
        case (off_i)
          OFF_SRC:  src_q <= wdata_i[ADDR_W-1:0];
          OFF_DST:  dst_q <= wdata_i[ADDR_W-1:0];
          OFF_CNT:  cnt_q <= wdata_i[CNT_W-1:0];
          OFF_STEP: begin
            sstep_q <= wdata_i[8];
            dstep_q <= wdata_i[STEP_W-1:0];
          end
          OFF_CTRL: begin
            en_q <= wdata_i[8];
            if (!busy_q) start_q <= wdata_i[0];
          end
          OFF_TSEL: tsel_q <= wdata_i[SEL_W-1:0];
          default: ;
        endcase
      end
      if (fire) begin
        busy_q  <= 1'b1;
        start_q <= 1'b0;
        rem_q   <= (cnt_q == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, cnt_q};
      end
      if (step_i) begin
        src_q <= src_q + (sstep_q ? ADDR_W'(4) : ADDR_W'(0));
        dst_q <= dst_q + ADDR_W'(dinc);
        rem_q <= rem_q - REM_W'(4);
        if (last) begin
          busy_q <= 1'b0;
          done_q <= 1'b1;
        end
      end
    end
  end

  always_comb begin
    rdata_o = '0;
    case (off_i)
      OFF_SRC:  rdata_o = 32'(src_q);
      OFF_DST:  rdata_o = 32'(dst_q);
      OFF_CNT:  rdata_o = 32'(cnt_q);
      OFF_STEP: rdata_o = {23'd0, sstep_q, 5'd0, dstep_q};
      OFF_CTRL: rdata_o = {23'd0, en_q, 3'd0, busy_q, 3'd0, start_q};
      OFF_TSEL: rdata_o = {29'd0, tsel_q};
      default:  rdata_o = '0;
    endcase
  end

  assign busy_o = busy_q;
  assign done_o = done_q;
  assign src_o  = src_q;
  assign dst_o  = dst_q;

  assert_step_busy_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    step_i |-> busy_q);
  assert_rem_live_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busy_q |-> rem_q != '0);
  assert_done_idle_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    done_q |-> !busy_q);
  assert_start_clear_R10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> !start_q);
  assert_enable_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $rose(busy_q) |-> $past(en_q));
endmodule

// File: rtl/dma3_arbiter.sv
module dma3_arbiter #(
  parameter int N = 3
) (
  input  logic [N-1:0] req_i,
  output logic [N-1:0] gnt_o
);
  always_comb begin
    gnt_o = '0;
    for (int i = N - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        gnt_o    = '0;
        gnt_o[i] = 1'b1;
      end
    end
  end
endmodule

// File: rtl/dma3_mover.sv
module dma3_mover
  import dma3_pkg::*;
#(
  parameter int N      = 3,
  parameter int ADDR_W = 27
) (
  input  logic                     clk_i,
  input  logic                     rst_ni,
  input  logic [N-1:0]             gnt_i,
  input  logic [N-1:0][ADDR_W-1:0] src_i,
  input  logic [N-1:0][ADDR_W-1:0] dst_i,
  output logic [N-1:0]             step_o,
  output logic                     mem_req_o,
  output logic                     mem_we_o,
  output logic [ADDR_W-1:0]        mem_addr_o,
  output logic [31:0]              mem_wdata_o,
  input  logic [31:0]              mem_rdata_i,
  input  logic                     mem_ack_i
);
  mv_state_e         state_q;
  logic [N-1:0]      sel_q;
  logic [ADDR_W-1:0] addr_q;
  logic [31:0]       data_q;
  logic [ADDR_W-1:0] src_pick, dst_pick;

  always_comb begin
    src_pick = '0;
    dst_pick = '0;
    for (int i = 0; i < N; i++) begin
      if (gnt_i[i]) src_pick |= src_i[i];
      if (sel_q[i]) dst_pick |= dst_i[i];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      state_q <= MV_IDLE;
      sel_q   <= '0;
      addr_q  <= '0;
      data_q  <= '0;
    end else begin
      case (state_q)
        MV_IDLE: if (|gnt_i) begin
          sel_q   <= gnt_i;
          addr_q  <= src_pick;
          state_q <= MV_RD;
        end
        MV_RD: if (mem_ack_i) begin
          data_q  <= mem_rdata_i;
          addr_q  <= dst_pick;
          state_q <= MV_WR;
        end
        MV_WR: if (mem_ack_i) state_q <= MV_IDLE;
        default: state_q <= MV_IDLE;
      endcase
    end
  end

  assign step_o      = (state_q == MV_WR && mem_ack_i) ? sel_q : '0;
  assign mem_req_o   = (state_q != MV_IDLE);
  assign mem_we_o    = (state_q == MV_WR);
  assign mem_addr_o  = addr_q;
  assign mem_wdata_o = data_q;

  assert_req_hold_R11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_ack_i) |=> (mem_req_o && $stable(mem_addr_o) && $stable(mem_we_o)));
  assert_rd_then_wr_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_req_o && !mem_we_o && mem_ack_i) |=> (mem_req_o && mem_we_o));
  assert_sel_onehot_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_req_o |-> $onehot(sel_q));
endmodule

// File: rtl/dma3_engine.sv
module dma3_engine
  import dma3_pkg::*;
#(
  parameter int NCH    = 3,
  parameter int ADDR_W = 27,
  parameter int CNT0_W = 20,
  parameter int CNTN_W = 12
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              reg_wr_i,
  input  logic [6:0]        reg_addr_i,
  input  logic [31:0]       reg_wdata_i,
  output logic [31:0]       reg_rdata_o,
  input  logic [6:0]        trig_i,
  output logic              mem_req_o,
  output logic              mem_we_o,
  output logic [ADDR_W-1:0] mem_addr_o,
  output logic [31:0]       mem_wdata_o,
  input  logic [31:0]       mem_rdata_i,
  input  logic              mem_ack_i,
  output logic [NCH-1:0]    done_o
);
  logic [1:0] bank;
  logic [2:0] off;
  assign bank = reg_addr_i[6:5];
  assign off  = reg_addr_i[4:2];

  logic [NCH-1:0][31:0]       ch_rdata;
  logic [NCH-1:0][ADDR_W-1:0] ch_src, ch_dst;
  logic [NCH-1:0]             busy, gnt, step;

  for (genvar c = 0; c < NCH; c++) begin : g_ch
    localparam int CW = (c == 0) ? CNT0_W : CNTN_W;
    dma3_channel #(.CNT_W(CW), .ADDR_W(ADDR_W)) u_ch (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .wr_i    (reg_wr_i && (bank == 2'(c))),
      .off_i   (off),
      .wdata_i (reg_wdata_i),
      .rdata_o (ch_rdata[c]),
      .trig_i  (trig_i),
      .step_i  (step[c]),
      .busy_o  (busy[c]),
      .done_o  (done_o[c]),
      .src_o   (ch_src[c]),
      .dst_o   (ch_dst[c])
    );
  end

  always_comb begin
    reg_rdata_o = '0;
    for (int c = 0; c < NCH; c++)
      if (bank == 2'(c)) reg_rdata_o = ch_rdata[c];
  end

  dma3_arbiter #(.N(NCH)) u_arb (
    .req_i (busy),
    .gnt_o (gnt)
  );

  dma3_mover #(.N(NCH), .ADDR_W(ADDR_W)) u_mv (
    .clk_i       (clk_i),
    .rst_ni      (rst_ni),
    .gnt_i       (gnt),
    .src_i       (ch_src),
    .dst_i       (ch_dst),
    .step_o      (step),
    .mem_req_o   (mem_req_o),
    .mem_we_o    (mem_we_o),
    .mem_addr_o  (mem_addr_o),
    .mem_wdata_o (mem_wdata_o),
    .mem_rdata_i (mem_rdata_i),
    .mem_ack_i   (mem_ack_i)
  );

  assert_gnt_onehot_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(gnt));
  assert_gnt_prio_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (|gnt) |-> (((gnt - 1'b1) & busy) == '0));
  assert_step_onehot_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(step));
endmodule

// File: tb/dma3_engine_test.sv
`timescale 1ns/100ps
module dma3_engine_test;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        reg_wr = 1'b0;
  logic [6:0]  reg_addr = '0;
  logic [31:0] reg_wdata = '0;
  logic [31:0] reg_rdata;
  logic [6:0]  trig = '0;
  logic        mem_req, mem_we, mem_ack;
  logic [26:0] mem_addr;
  logic [31:0] mem_wdata, mem_rdata;
  logic [2:0]  done;

  always #2.5 clk = ~clk;

  dma3_engine uut (
    .clk_i(clk), .rst_ni(rst_n), .reg_wr_i(reg_wr), .reg_addr_i(reg_addr),
    .reg_wdata_i(reg_wdata), .reg_rdata_o(reg_rdata), .trig_i(trig),
    .mem_req_o(mem_req), .mem_we_o(mem_we), .mem_addr_o(mem_addr),
    .mem_wdata_o(mem_wdata), .mem_rdata_i(mem_rdata), .mem_ack_i(mem_ack),
    .done_o(done)
  );

  // memory model with programmable acknowledge latency
  logic [31:0] mem [256];
  logic [26:0] lg_addr [4096];
  logic        lg_we   [4096];
  logic [31:0] lg_data [4096];
  int log_n, lat, acnt, hold_err;
  int done_cnt [3];
  logic prev_pend;
  logic [26:0] prev_addr;

  assign mem_rdata = mem[mem_addr[9:2]];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mem_ack <= 1'b0; acnt <= 0; log_n <= 0; hold_err <= 0;
      prev_pend <= 1'b0; prev_addr <= '0;
      for (int i = 0; i < 256; i++) mem[i] <= 32'hA500_0000 + i;
      for (int i = 0; i < 3; i++) done_cnt[i] <= 0;
    end else begin
      prev_pend <= mem_req & ~mem_ack;
      prev_addr <= mem_addr;
      if (prev_pend && !(mem_req && mem_addr == prev_addr)) hold_err <= hold_err + 1;
      if (mem_ack) mem_ack <= 1'b0;
      else if (mem_req) begin
        if (acnt >= lat) begin mem_ack <= 1'b1; acnt <= 0; end
        else acnt <= acnt + 1;
      end
      if (mem_req && mem_ack) begin
        lg_addr[log_n % 4096] <= mem_addr;
        lg_we[log_n % 4096]   <= mem_we;
        lg_data[log_n % 4096] <= mem_we ? mem_wdata : mem_rdata;
        log_n <= log_n + 1;
        if (mem_we) mem[mem_addr[9:2]] <= mem_wdata;
      end
      for (int i = 0; i < 3; i++) if (done[i]) done_cnt[i] <= done_cnt[i] + 1;
    end
  end

  int n_chk = 0, n_fail = 0;

  task automatic chk(input bit ok, input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", req, act, exp);
    end
  endtask

  task automatic wr(input int ch, input int off, input logic [31:0] d);
    @(negedge clk);
    reg_wr = 1'b1; reg_addr = 7'(ch * 32 + off); reg_wdata = d;
    @(negedge clk);
    reg_wr = 1'b0;
  endtask

  task automatic rd(input int ch, input int off, output logic [31:0] d);
    @(negedge clk);
    reg_addr = 7'(ch * 32 + off);
    #1 d = reg_rdata;
  endtask

  task automatic rd_chk(input int ch, input int off, input logic [31:0] exp, input string req);
    logic [31:0] d;
    rd(ch, off, d);
    chk(d === exp, req, d, exp);
  endtask

  task automatic wait_done(input int ch, input int base, input string req);
    int i;
    for (i = 0; i < 20000; i++) begin
      if (done_cnt[ch] > base) break;
      @(posedge clk);
    end
    chk(i < 20000, req, 32'(done_cnt[ch]), 32'(base + 1));
    @(negedge clk);
  endtask

  task automatic setup(input int ch, input logic [31:0] src, input logic [31:0] dst,
                       input logic [31:0] cnt, input logic sstep, input logic [2:0] dstep,
                       input logic [2:0] tsel);
    wr(ch, 'h00, src);
    wr(ch, 'h04, dst);
    wr(ch, 'h08, cnt);
    wr(ch, 'h0C, {23'd0, sstep, 5'd0, dstep});
    wr(ch, 'h14, {29'd0, tsel});
  endtask

  // check word k of a run logged from entry base
  task automatic chk_word(input int base, input int k, input logic [26:0] sa, input logic [26:0] da,
                          input string req);
    int r = base + 2 * k;
    logic [31:0] exp = 32'hA500_0000 + 32'(sa[9:2]);
    chk(lg_addr[r] == sa && !lg_we[r], req, 32'(lg_addr[r]), 32'(sa));
    chk(lg_data[r] == exp, req, lg_data[r], exp);
    chk(lg_addr[r+1] == da && lg_we[r+1] && lg_data[r+1] == lg_data[r], req,
        32'(lg_addr[r+1]), 32'(da));
  endtask

  task automatic t_reset();
    rd_chk(0, 'h10, 32'h0, "R1 reset ctrl");
    rd_chk(2, 'h08, 32'h0, "R1 reset count");
    chk(!mem_req && done == 3'b000, "R8 reset outputs", {28'd0, mem_req, done}, 32'h0);
  endtask

  task automatic t_regs();
    wr(0, 'h00, 32'hFFFF_FFFF); rd_chk(0, 'h00, 32'h07FF_FFFF, "R1 src width");
    wr(1, 'h04, 32'hFFFF_FFFF); rd_chk(1, 'h04, 32'h07FF_FFFF, "R1 dst width");
    wr(0, 'h08, 32'hFFFF_FFFF); rd_chk(0, 'h08, 32'h000F_FFFF, "R1 ch0 count width");
    wr(2, 'h08, 32'hFFFF_FFFF); rd_chk(2, 'h08, 32'h0000_0FFF, "R1 ch2 count width");
    wr(1, 'h0C, 32'hFFFF_FFFF); rd_chk(1, 'h0C, 32'h0000_0107, "R1 step fields");
    wr(2, 'h14, 32'hFFFF_FFFF); rd_chk(2, 'h14, 32'h0000_0007, "R1 trigger field");
    wr(2, 'h10, 32'h0000_0110); rd_chk(2, 'h10, 32'h0000_0100, "R1 busy read-only");
    wr(2, 'h10, 32'h0); wr(2, 'h14, 32'h0);
    rd_chk(0, 'h00, 32'h07FF_FFFF, "R1 bank isolation");
  endtask

  task automatic t_soft();
    int b = log_n, d0 = done_cnt[0];
    setup(0, 'h0C0, 'h200, 12, 1'b1, 3'd2, 3'd7);
    wr(0, 'h10, 32'h101);
    wait_done(0, d0, "R8 soft run done");
    chk(log_n - b == 6, "R7 three words for count 12", 32'(log_n - b), 6);
    for (int k = 0; k < 3; k++) chk_word(b, k, 27'('h0C0 + 4*k), 27'('h200 + 4*k), "R4 R5 soft word");
    rd_chk(0, 'h00, 32'h0CC, "R5 final source");
    rd_chk(0, 'h04, 32'h20C, "R6 final dest");
    rd_chk(0, 'h08, 32'd12, "R7 count register kept");
    rd_chk(0, 'h10, 32'h100, "R10 start cleared busy 0");
    repeat (3) @(negedge clk);
    chk(done_cnt[0] == d0 + 1, "R8 single done pulse", 32'(done_cnt[0]), 32'(d0 + 1));
  endtask

  task automatic t_steps();
    logic [2:0] codes [4] = '{3'd0, 3'd1, 3'd3, 3'd7};
    for (int i = 0; i < 4; i++) begin
      int b = log_n, d0 = done_cnt[0];
      int inc = (codes[i] == 0) ? 0 : (1 << codes[i]);
      setup(0, 'h040, 'h300, 8, 1'b0, codes[i], 3'd7);
      wr(0, 'h10, 32'h101);
      wait_done(0, d0, "R6 step run done");
      chk_word(b, 0, 27'h040, 27'h300, "R5 R6 first word");
      chk_word(b, 1, 27'h040, 27'('h300 + inc), "R5 R6 second word");
    end
  endtask

  task automatic t_codes();
    for (int c = 0; c < 7; c++) begin
      int b, d0 = done_cnt[2];
      setup(2, 'h020, 'h3C0, 4, 1'b1, 3'd2, 3'(c));
      wr(2, 'h10, 32'h000);
      trig[c] = 1'b1; @(negedge clk); trig[c] = 1'b0;
      repeat (10) @(negedge clk);
      chk(done_cnt[2] == d0, "R2 disabled ignores trigger", 32'(done_cnt[2]), 32'(d0));
      wr(2, 'h10, 32'h100);
      b = log_n;
      trig[(c + 1) % 7] = 1'b1; @(negedge clk); trig[(c + 1) % 7] = 1'b0;
      repeat (10) @(negedge clk);
      chk(log_n == b, "R2 wrong source ignored", 32'(log_n), 32'(b));
      trig[c] = 1'b1; @(negedge clk); trig[c] = 1'b0;
      wait_done(2, d0, "R2 selected source starts");
      wr(2, 'h10, 32'h000);
    end
  endtask

  task automatic t_edge();
    int b = log_n, d0 = done_cnt[1];
    setup(1, 'h010, 'h240, 16, 1'b1, 3'd2, 3'd4);
    wr(1, 'h10, 32'h100);
    trig[4] = 1'b1;
    repeat (4) @(negedge clk);
    trig[4] = 1'b0; @(negedge clk);
    trig[4] = 1'b1; @(negedge clk);
    trig[4] = 1'b0;
    wait_done(1, d0, "R3 run done");
    trig[4] = 1'b1;
    repeat (60) @(negedge clk);
    chk(done_cnt[1] == d0 + 2, "R3 held level one run", 32'(done_cnt[1]), 32'(d0 + 2));
    trig[4] = 1'b0;
    chk(log_n - b == 16, "R3 busy edge dropped", 32'(log_n - b), 16);
    wr(1, 'h10, 32'h0);
  endtask

  task automatic t_prio();
    int b, nrd = 0, p;
    int ids [64];
    int d2 = done_cnt[2];
    lat = 6;
    setup(0, 'h000, 'h200, 8, 1'b1, 3'd2, 3'd7);
    setup(1, 'h040, 'h280, 8, 1'b1, 3'd2, 3'd7);
    setup(2, 'h080, 'h300, 32, 1'b1, 3'd2, 3'd7);
    b = log_n;
    wr(2, 'h10, 32'h101);
    while (log_n == b) @(negedge clk);
    wr(1, 'h10, 32'h101);
    wr(0, 'h10, 32'h101);
    rd_chk(2, 'h10, 32'h110, "R10 start reads 0 while busy");
    wait_done(2, d2, "R9 all runs done");
    for (int i = b; i < log_n; i += 2) begin
      ids[nrd] = int'(lg_addr[i][7:6]);
      chk(int'(lg_addr[i+1][8:7]) - 0 == ids[nrd] + 4 - 4 + (lg_addr[i+1][9] ? 0 : 0) &&
          ((int'(lg_addr[i+1]) >> 7) - 4) == ids[nrd], "R9 word not split",
          32'(lg_addr[i+1]), 32'(lg_addr[i]));
      nrd++;
    end
    chk(nrd == 12 && ids[0] == 2, "R9 ch2 first", 32'(ids[0]), 2);
    p = 0;
    while (p < nrd && ids[p] == 2) p++;
    chk(p < nrd - 3 && ids[p] == 0 && ids[p+1] == 0 && ids[p+2] == 1 && ids[p+3] == 1,
        "R9 order ch0 then ch1", 32'(ids[p]), 0);
    for (int i = p + 4; i < nrd; i++) chk(ids[i] == 2, "R9 ch2 resumes", 32'(ids[i]), 2);
    chk(hold_err == 0, "R11 request held until ack", 32'(hold_err), 0);
    lat = 0;
  endtask

  task automatic t_count();
    int b = log_n, d1 = done_cnt[1];
    setup(1, 'h010, 'h3F0, 0, 1'b0, 3'd0, 3'd7);
    wr(1, 'h10, 32'h101);
    wait_done(1, d1, "R7 zero count done");
    chk(log_n - b == 2048, "R7 zero count 4096 bytes", 32'(log_n - b), 2048);
    b = log_n; d1 = done_cnt[1];
    setup(1, 'h010, 'h3F0, 6, 1'b0, 3'd0, 3'd7);
    wr(1, 'h10, 32'h101);
    wait_done(1, d1, "R7 odd count done");
    chk(log_n - b == 4, "R7 count 6 two words", 32'(log_n - b), 4);
    rd_chk(1, 'h10, 32'h100, "R8 busy cleared");
  endtask

  initial begin
    bit wd = 1'b0;
    lat = 0;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    fork
      begin
        t_reset();
        t_regs();
        t_soft();
        t_steps();
        t_codes();
        t_edge();
        t_prio();
        t_count();
      end
      begin
        repeat (190000) @(posedge clk);
        wd = 1'b1;
      end
    join_any
    disable fork;
    if (wd) chk(1'b0, "watchdog", 32'd0, 32'd1);
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_fail);
    $finish;
  end
endmodule